// File: doc/BRIEF.md
# Data-Ready Serial Output Port

This block is the device side of a read-only two-wire serial port on a converter. It keeps the most recent conversion result and announces it on one combined line that first acts as a ready flag and then carries the data. A host waits for the line to go low, then supplies serial clock pulses and receives a 24-bit frame. The frame holds the result, four zero pad bits and a status byte whose fixed check pattern lets the host verify the transfer.

Each result is offered once. When a new result arrives, the line is forced high for a guard window of system clocks before the word is loaded. This means a host never reads a word while it is being replaced, and any partial read in progress is dropped. An active-low power-down/reset pin releases the line (output enable low) and clears the interface. A reset pulse must last a minimum number of system clocks to take effect. After a reset, the first results are withheld until the converter's filter has settled. The serial clock and the pin are brought into the system clock domain through flop synchronizers.

Top module: `drdy_serial_port`

## Requirements
- R1: After system reset with the power-down pin high, the output enable is 1, the line is high and no word is offered.
- R2: After a reset, the first SETTLE_DISCARD results (default 2) are dropped and the line stays high. The next result is offered.
- R3: The frame is 24 bits, sent MSB first. Bits 23..12 hold the result. Bits 11..8 are zero. Bit 7 is the ready bit, 0. Bit 6 is 0. Bit 5 is the error flag. Bits 4..3 are the ID, 00. Bits 2..0 are the pattern 101.
- R4: When a result is accepted, the line is high from the strobe's clock edge for GUARD_CYC system clocks (default 4). The line then falls, because the word is loaded and its ready bit is low.
- R5: On the rising serial clock edge after the 24th bit, the line returns high. Further serial clocks leave it high and the word is not sent again.
- R6: A result that arrives during a partial read abandons that read. Only the new word is then delivered.
- R7: The line moves to the next bit only on a falling serial clock edge. It stays stable through the high phase.
- R8: When the pin is low for MIN_PD_CYC synchronized clocks (default 8), the output enable drops to 0, the interface is cleared and results are ignored. On release the line is high and the R2 settling discard applies again.
- R9: A low pulse on the pin shorter than MIN_PD_CYC clocks is ignored, and a loaded word stays readable.
- R10: The error flag in the frame equals the out-of-range input of that result.
- R11: A second result during the guard window replaces the first and restarts the window. Only the second is delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high system reset |
| res_valid | input | 1 | One-cycle strobe: a new conversion result |
| res_code | input | RES_W | Conversion result, offset binary |
| res_oor | input | 1 | Analog input was out of range for this result |
| sclk_pin | input | 1 | Serial clock from the host, asynchronous, idles high |
| pdrst_n_pin | input | 1 | Power-down/reset pin, active low, asynchronous |
| dout_rdy | output | 1 | Combined ready/data line |
| dout_oe | output | 1 | Output enable for the line; 0 means tristated |

## Verification
Two functions can fall in the same cycle: a new-result strobe can land while the shifter is part way through a frame, or while a previous result is still in its guard window. The bench provokes the first by stopping a read after ten bits and strobing. It judges the outcome by the line rising on the strobe edge, falling exactly one guard window later, and a full read returning only the new word. The second case is provoked by two strobes a couple of clocks apart. Here the line must stay high until a full window after the later strobe, and the delivered frame must carry the later code.

// File: rtl/drdy_pkg.sv
package drdy_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_GUARD  = 2'd1,
    ST_LOADED = 2'd2
  } port_state_e;

  // status byte: ready(0), zero, error, id[1:0], pattern[2:0]
  function automatic logic [7:0] status_byte(input logic err,
                                             input logic [1:0] id,
                                             input logic [2:0] pat);
    return {1'b0, 1'b0, err, id, pat};
  endfunction

endpackage

// File: rtl/drdy_sync.sv
module drdy_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= {STAGES{RST_VAL}};
    else     pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/drdy_pd_filter.sv
module drdy_pd_filter #(
  parameter int MIN_CYC = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_s,
  output logic pd_active
);

  localparam int CNT_W = $clog2(MIN_CYC + 1);

  logic [CNT_W-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt   <= '0;
      pd_active <= 1'b0;
    end else if (pin_s) begin
      low_cnt   <= '0;
      pd_active <= 1'b0;
    end else if (low_cnt == CNT_W'(MIN_CYC - 1)) begin
      pd_active <= 1'b1;
    end else begin
      low_cnt <= low_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/drdy_frame_shifter.sv
module drdy_frame_shifter #(
  parameter int FRAME_W = 24
) (
  input  logic               clk,
  input  logic               clr,
  input  logic               load,
  input  logic               abort,
  input  logic [FRAME_W-1:0] frame,
  input  logic               sclk_fall,
  input  logic               sclk_rise,
  output logic               line,
  output logic               busy,
  output logic               done
);

  localparam int IDX_W = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] sreg;
  logic [IDX_W-1:0]   idx;

  always_ff @(posedge clk) begin
    done <= 1'b0;
    if (clr) begin
      sreg <= '0;
      idx  <= '0;
      busy <= 1'b0;
      line <= 1'b1;
    end else if (abort) begin
      idx  <= '0;
      busy <= 1'b0;
      line <= 1'b1;
    end else if (load) begin
      sreg <= frame;
      idx  <= '0;
      busy <= 1'b1;
      line <= 1'b0;
    end else if (busy) begin
      if (sclk_fall && idx != IDX_W'(FRAME_W)) begin
        line <= sreg[FRAME_W-1];
        sreg <= {sreg[FRAME_W-2:0], 1'b0};
        idx  <= idx + 1'b1;
      end else if (sclk_rise && idx == IDX_W'(FRAME_W)) begin
        busy <= 1'b0;
        line <= 1'b1;
        done <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/drdy_serial_port.sv
module drdy_serial_port #(
  parameter int         RES_W          = 12,
  parameter int         PAD_W          = 4,
  parameter int         GUARD_CYC      = 4,
  parameter int         MIN_PD_CYC     = 8,
  parameter int         SETTLE_DISCARD = 2,
  parameter int         SYNC_STAGES    = 2,
  parameter logic [1:0] DEV_ID         = 2'b00,
  parameter logic [2:0] CHK_PAT        = 3'b101
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             res_valid,
  input  logic [RES_W-1:0] res_code,
  input  logic             res_oor,
  input  logic             sclk_pin,
  input  logic             pdrst_n_pin,
  output logic             dout_rdy,
  output logic             dout_oe
);
  import drdy_pkg::*;

  localparam int FRAME_W = RES_W + PAD_W + 8;
  localparam int GC_W    = $clog2(GUARD_CYC + 2);
  localparam int DC_W    = $clog2(SETTLE_DISCARD + 2);
  localparam int N_PINS  = 2;

  // pin synchronizers: index 0 = serial clock, 1 = power-down pin
  logic [N_PINS-1:0] pins_raw, pins_s;
  assign pins_raw = {pdrst_n_pin, sclk_pin};

  for (genvar g = 0; g < N_PINS; g++) begin : g_sync
    drdy_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk(clk), .rst(rst), .d(pins_raw[g]), .q(pins_s[g])
    );
  end

  logic sclk_d, sclk_fall, sclk_rise;
  always_ff @(posedge clk) begin
    if (rst) sclk_d <= 1'b1;
    else     sclk_d <= pins_s[0];
  end
  assign sclk_fall = sclk_d & ~pins_s[0];
  assign sclk_rise = ~sclk_d & pins_s[0];

  logic pd_active;
  drdy_pd_filter #(.MIN_CYC(MIN_PD_CYC)) u_pd (
    .clk(clk), .rst(rst), .pin_s(pins_s[1]), .pd_active(pd_active)
  );

  logic clr;
  assign clr = rst | pd_active;

  port_state_e      state;
  logic [GC_W-1:0]  guard_cnt;
  logic [DC_W-1:0]  discard_cnt;
  logic [RES_W-1:0] stage_code;
  logic             stage_oor;
  logic             accept, load, abort, sh_busy, sh_done, sh_line;

  assign accept = res_valid && (discard_cnt == '0);
  assign abort  = accept;
  assign load   = (state == ST_GUARD) && (guard_cnt == GC_W'(1)) && !res_valid;

  always_ff @(posedge clk) begin
    if (clr) begin
      state       <= ST_IDLE;
      guard_cnt   <= '0;
      discard_cnt <= DC_W'(SETTLE_DISCARD);
      stage_code  <= '0;
      stage_oor   <= 1'b0;
    end else if (res_valid) begin
      if (discard_cnt != '0) begin
        discard_cnt <= discard_cnt - 1'b1;
      end else begin
        stage_code <= res_code;
        stage_oor  <= res_oor;
        guard_cnt  <= GC_W'(GUARD_CYC);
        state      <= ST_GUARD;
      end
    end else begin
      unique case (state)
        ST_GUARD: begin
          if (guard_cnt == GC_W'(1)) state <= ST_LOADED;
          else                       guard_cnt <= guard_cnt - 1'b1;
        end
        ST_LOADED: if (sh_done) state <= ST_IDLE;
        default: ;
      endcase
    end
  end

  logic [FRAME_W-1:0] frame;
  assign frame = {stage_code, {PAD_W{1'b0}}, status_byte(stage_oor, DEV_ID, CHK_PAT)};

  drdy_frame_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk(clk), .clr(clr), .load(load), .abort(abort), .frame(frame),
    .sclk_fall(sclk_fall), .sclk_rise(sclk_rise),
    .line(sh_line), .busy(sh_busy), .done(sh_done)
  );

  always_ff @(posedge clk) begin
    if (rst) dout_oe <= 1'b0;
    else     dout_oe <= ~pd_active;
  end

  assign dout_rdy = sh_line;

endmodule

// File: rtl/drdy_port_chk.sv
module drdy_port_chk #(
  parameter int DC_W = 2
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      pd_active,
  input drdy_pkg::port_state_e     state,
  input logic [DC_W-1:0]           discard_cnt,
  input logic                      sh_busy,
  input logic                      sclk_fall,
  input logic                      sclk_rise,
  input logic                      load,
  input logic                      abort,
  input logic                      dout_rdy,
  input logic                      dout_oe
);
  import drdy_pkg::*;

  // R8
  pd_tristate_chk: assert property (@(posedge clk) disable iff (rst)
    pd_active |=> !dout_oe);

  // R4
  guard_high_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_GUARD) |-> dout_rdy);

  // R5
  idle_high_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> dout_rdy);

  // R7
  hold_between_edges_chk: assert property (@(posedge clk) disable iff (rst)
    (sh_busy && !sclk_fall && !sclk_rise && !load && !abort && !pd_active)
      |=> $stable(dout_rdy));

  // R2
  settle_no_word_chk: assert property (@(posedge clk) disable iff (rst)
    (discard_cnt != '0) |-> (state != ST_LOADED));

endmodule

bind drdy_serial_port drdy_port_chk #(.DC_W(DC_W)) u_chk (
  .clk(clk), .rst(rst), .pd_active(pd_active), .state(state),
  .discard_cnt(discard_cnt), .sh_busy(sh_busy), .sclk_fall(sclk_fall),
  .sclk_rise(sclk_rise), .load(load), .abort(abort),
  .dout_rdy(dout_rdy), .dout_oe(dout_oe)
);

// File: tb/tb_drdy_serial_port.sv
module tb_drdy_serial_port;

  localparam int G      = 4;
  localparam int MINPD  = 8;
  localparam int HALF   = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic res_valid = 1'b0;
  logic [11:0] res_code = '0;
  logic res_oor = 1'b0;
  logic sclk_pin = 1'b1;
  logic pdrst_n_pin = 1'b1;
  logic dout_rdy, dout_oe;

  always #10 clk = ~clk;

  drdy_serial_port dut (
    .clk(clk), .rst(rst), .res_valid(res_valid), .res_code(res_code),
    .res_oor(res_oor), .sclk_pin(sclk_pin), .pdrst_n_pin(pdrst_n_pin),
    .dout_rdy(dout_rdy), .dout_oe(dout_oe)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [23:0] expq[$];
  logic [23:0] rxq[$];

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // R3 R10: expected frame built from the stated layout
  function automatic logic [23:0] exp_frame(input logic [11:0] c, input logic e);
    return {c, 4'h0, 1'b0, 1'b0, e, 2'b00, 3'b101};
  endfunction

  // driver: one-cycle strobe; optional push and R4 guard timing check
  task automatic strobe(input logic [11:0] c, input logic e,
                        input bit push, input bit tcheck);
    @(negedge clk);
    res_valid = 1'b1; res_code = c; res_oor = e;
    @(negedge clk);
    res_valid = 1'b0;
    if (push) expq.push_back(exp_frame(c, e));
    if (tcheck) begin
      check(dout_rdy === 1'b1, "R4 high at strobe edge", dout_rdy, 1);
      for (int i = 1; i < G; i++) begin
        @(negedge clk);
        check(dout_rdy === 1'b1, "R4 high in guard", dout_rdy, 1);
      end
      @(negedge clk);
      check(dout_rdy === 1'b0, "R4 falls after guard", dout_rdy, 0);
    end
  endtask

  task automatic serial_read(input int nbits, input bit full,
                             output logic [23:0] word, output bit stable_ok);
    logic b_lo;
    word = '0;
    stable_ok = 1'b1;
    for (int i = 0; i < nbits; i++) begin
      sclk_pin = 1'b0;
      repeat (HALF) @(negedge clk);
      b_lo = dout_rdy;
      sclk_pin = 1'b1;
      repeat (HALF) @(negedge clk);
      if (!(full && i == nbits - 1) && dout_rdy !== b_lo) stable_ok = 1'b0;
      word = {word[22:0], b_lo};
    end
    if (full) rxq.push_back(word);
  endtask

  // monitor: pops received frames and compares them with the scoreboard
  initial begin
    forever begin
      logic [23:0] got, exp;
      wait (rxq.size() > 0);
      got = rxq.pop_front();
      if (expq.size() == 0) begin
        check(1'b0, "R3 unexpected frame", got, 0);
      end else begin
        exp = expq.pop_front();
        check(got === exp, "R3 R10 frame content", got, exp);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    summary();
  end

  task automatic full_read_and_release();
    logic [23:0] w;
    bit st;
    serial_read(24, 1'b1, w, st);
    check(st, "R7 stable through high phase", st, 1);
    check(dout_rdy === 1'b1, "R5 high after read", dout_rdy, 1);
  endtask

  initial begin
    logic [23:0] w;
    bit st;

    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (6) @(negedge clk);
    // R1
    check(dout_oe === 1'b1, "R1 oe after reset", dout_oe, 1);
    check(dout_rdy === 1'b1, "R1 line after reset", dout_rdy, 1);

    // R2: first two results dropped
    strobe(12'h111, 1'b0, 1'b0, 1'b0);
    repeat (G + 3) @(negedge clk);
    check(dout_rdy === 1'b1, "R2 first result dropped", dout_rdy, 1);
    strobe(12'h222, 1'b0, 1'b0, 1'b0);
    repeat (G + 3) @(negedge clk);
    check(dout_rdy === 1'b1, "R2 second result dropped", dout_rdy, 1);
    strobe(12'hA5C, 1'b0, 1'b1, 1'b1);
    full_read_and_release();

    // R5: extra clocks, line must stay high, nothing resent
    serial_read(24, 1'b0, w, st);
    check(w === 24'hFFFFFF, "R5 no second read", w, 24'hFFFFFF);

    // R3 R10 patterns
    strobe(12'hFFF, 1'b1, 1'b1, 1'b1);
    full_read_and_release();
    strobe(12'h000, 1'b0, 1'b1, 1'b1);
    full_read_and_release();
    strobe(12'h800, 1'b1, 1'b1, 1'b1);
    full_read_and_release();

    // R6: partial read abandoned by a new result
    strobe(12'h123, 1'b0, 1'b0, 1'b1);
    serial_read(10, 1'b0, w, st);
    check(w[9:0] === exp_frame(12'h123, 1'b0)[23:14], "R6 R7 partial bits",
          w[9:0], exp_frame(12'h123, 1'b0)[23:14]);
    strobe(12'h456, 1'b1, 1'b1, 1'b1);
    full_read_and_release();

    // R11: second result inside the guard window wins
    strobe(12'h321, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    strobe(12'h654, 1'b0, 1'b1, 1'b1);
    full_read_and_release();

    // R9: short low pulse ignored
    strobe(12'h3C3, 1'b0, 1'b1, 1'b1);
    pdrst_n_pin = 1'b0;
    repeat (MINPD - 3) @(negedge clk);
    pdrst_n_pin = 1'b1;
    repeat (10) @(negedge clk);
    check(dout_oe === 1'b1, "R9 oe kept", dout_oe, 1);
    check(dout_rdy === 1'b0, "R9 word kept", dout_rdy, 0);
    full_read_and_release();

    // R8: long low pulse resets interface
    strobe(12'h0F0, 1'b0, 1'b0, 1'b1);
    pdrst_n_pin = 1'b0;
    repeat (20) @(negedge clk);
    check(dout_oe === 1'b0, "R8 tristated", dout_oe, 0);
    strobe(12'h777, 1'b0, 1'b0, 1'b0);
    repeat (G + 3) @(negedge clk);
    check(dout_oe === 1'b0, "R8 still tristated", dout_oe, 0);
    pdrst_n_pin = 1'b1;
    repeat (6) @(negedge clk);
    check(dout_oe === 1'b1, "R8 oe after release", dout_oe, 1);
    check(dout_rdy === 1'b1, "R8 line high after release", dout_rdy, 1);
    strobe(12'h001, 1'b0, 1'b0, 1'b0);
    strobe(12'h002, 1'b0, 1'b0, 1'b0);
    repeat (G + 3) @(negedge clk);
    check(dout_rdy === 1'b1, "R8 R2 settle after release", dout_rdy, 1);
    strobe(12'h7FE, 1'b1, 1'b1, 1'b1);
    full_read_and_release();

    wait (rxq.size() == 0);
    repeat (5) @(negedge clk);
    check(expq.size() == 0, "R6 R11 no missing frame", expq.size(), 0);
    summary();
  end

endmodule